// File: doc/BRIEF.md
# Parallel ATA PIO Host Cycle Engine

This block sits between a simple 32-bit register bus and a CompactFlash card run in True IDE mode. Software programs a packed timing word, a configuration word and an enable bit. It then reaches the device's command-block and control-block registers through a window of bus offsets. Every access to that window becomes exactly one device bus cycle. Each cycle has three phases: a setup phase with chip select and address valid, an active phase with a read or write strobe low, and a recovery phase. The active phase can be stretched by the device's ready line.

Reads are posted. A bus read of a device register only launches the device read cycle. The byte or word that the device returns is latched at the end of the strobe and is collected later from a read-data register. A status word reports in its top nibble whether an access is still in flight. One extra access may be held while a cycle runs. An interrupt status register with write-one-to-clear bits and a mask drives a single interrupt output.

Top module: `pata_pio_host`

## Requirements
- R1: After reset the control word reads 0, the timing word reads 0x000171C6 (setup 6, active 28, recovery 23), the configuration word reads 0, and both chip selects and both strobes are high.
- R2: Bit 0 of the control word at offset 0x00 enables the engine. While it is 0, accesses to the device window (0x54 to 0x74) start no bus cycle.
- R3: The timing word at 0x2C holds the setup count in bits 3:0, the active count in bits 11:4 and the recovery count in bits 19:12. Each phase lasts its count plus one clock. Chip select and address are driven in all three phases. The read or write strobe is low only in the active phase.
- R4: With bit 1 of the configuration word at 0x18 set, once the active count has elapsed the active phase keeps extending for as long as the ready input is low. With that bit clear, the ready input has no effect.
- R5: Offsets 0x54, 0x58, 0x5C, 0x60, 0x64, 0x68, 0x6C and 0x70 drive chip select 0 with device address 0 to 7 in that order. Offset 0x74 drives chip select 1 with device address 6. Only one chip select is low at a time.
- R6: A read of a device-window offset starts a read cycle. The device data is latched on the last active clock. Offset 0x7C then returns it zero-extended: all 16 bits for offset 0x54, the low byte for the other offsets.
- R7: Bit 6 of the configuration word exchanges the two bytes of each data-port (0x54) word, both on writes and on latched reads. Byte registers are not affected.
- R8: The status word at 0x80 shows bit 28 = cycle in progress and bit 29 = an access is held waiting. All other bits are 0, and the word is 0 when the engine is idle.
- R9: An access that arrives while a cycle runs, or while an access is held, is kept in a one-entry holding slot and issued after the current cycle. An access that arrives while the slot is occupied and not being drained is dropped.
- R10: The interrupt status word at 0x10 sets bit 0 on the final recovery clock of every cycle and sets bit 1 while the device interrupt input is high. Writing 1 to a bit clears it. A set in the same clock wins over the clear.
- R11: The interrupt output is high exactly when some status bit is set whose bit in the mask word at 0x14 is also set.
- R12: A write cycle drives the data bus for the whole cycle: 16 bits from offset 0x54, or the written byte with a zero upper byte for the other offsets. Read cycles never drive the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one clock per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after the access |
| ata_dd_in | input | 16 | Device data bus, input side |
| ata_dd_out | output | 16 | Device data bus, output side |
| ata_dd_oe | output | 1 | Output enable for the device data bus |
| ata_da | output | 3 | Device register address |
| ata_cs0_n | output | 1 | Command-block chip select, active low |
| ata_cs1_n | output | 1 | Control-block chip select, active low |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_iordy | input | 1 | Device ready, low to stretch the strobe |
| ata_intrq | input | 1 | Device interrupt request |
| irq | output | 1 | Masked interrupt output |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a new access arriving on the final recovery clock. The bench waits for its own model to show the last recovery clock and then issues the access in exactly that cycle. The access must be parked and then issued one clock later with no strobe lost, and the per-clock comparison of chip selects, address and strobes judges it. The second pair is a write-one-to-clear landing on the clock where a cycle completes. The bench provokes it the same way, and a following read of the interrupt status must still show bit 0 set.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

  localparam int DW = 16;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  typedef struct packed {
    logic          we;
    logic          cs1;
    logic [2:0]    da;
    logic          is_word;
    logic [DW-1:0] data;
  } dev_acc_t;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_ISR  = 8'h10;
  localparam logic [7:0] OFS_IMR  = 8'h14;
  localparam logic [7:0] OFS_CFG  = 8'h18;
  localparam logic [7:0] OFS_TIM  = 8'h2C;
  localparam logic [7:0] OFS_DATA = 8'h54;
  localparam logic [7:0] OFS_ALT  = 8'h74;
  localparam logic [7:0] OFS_RDAT = 8'h7C;
  localparam logic [7:0] OFS_STAT = 8'h80;

  localparam int CFG_IORDY_BIT = 1;
  localparam int CFG_SWAP_BIT  = 6;

  function automatic logic [DW-1:0] swap_bytes(input logic [DW-1:0] w);
    return {w[7:0], w[DW-1:8]};
  endfunction

endpackage

// File: rtl/pata_regfile.sv
module pata_regfile
  import pata_pio_pkg::*;
#(
  parameter int SET_W   = 4,
  parameter int ACT_W   = 8,
  parameter int REC_W   = 8,
  parameter int IRQ_W   = 2,
  parameter int SET_RST = 6,
  parameter int ACT_RST = 28,
  parameter int REC_RST = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_cfg,
  input  logic             wr_tim,
  input  logic             wr_isr,
  input  logic             wr_imr,
  input  logic [31:0]      wdata,
  input  logic             cyc_done,
  input  logic             dev_intrq,
  output logic             en,
  output logic             iordy_en,
  output logic             swap,
  output logic [SET_W-1:0] tim_set,
  output logic [ACT_W-1:0] tim_act,
  output logic [REC_W-1:0] tim_rec,
  output logic [IRQ_W-1:0] isr,
  output logic [IRQ_W-1:0] imr,
  output logic             irq
);

  localparam int ACT_LSB = SET_W;
  localparam int REC_LSB = SET_W + ACT_W;

  logic             en_q, en_d;
  logic             iordy_q, iordy_d;
  logic             swap_q, swap_d;
  logic [SET_W-1:0] set_q, set_d;
  logic [ACT_W-1:0] act_q, act_d;
  logic [REC_W-1:0] rec_q, rec_d;
  logic [IRQ_W-1:0] isr_q, isr_d;
  logic [IRQ_W-1:0] imr_q, imr_d;
  logic [IRQ_W-1:0] isr_set;

  always_comb begin
    isr_set    = '0;
    isr_set[0] = cyc_done;
    isr_set[1] = dev_intrq;
  end

  always_comb begin
    en_d    = en_q;
    iordy_d = iordy_q;
    swap_d  = swap_q;
    set_d   = set_q;
    act_d   = act_q;
    rec_d   = rec_q;
    imr_d   = imr_q;
    isr_d   = isr_q;
    if (wr_ctrl) en_d = wdata[0];
    if (wr_cfg) begin
      iordy_d = wdata[CFG_IORDY_BIT];
      swap_d  = wdata[CFG_SWAP_BIT];
    end
    if (wr_tim) begin
      set_d = wdata[0 +: SET_W];
      act_d = wdata[ACT_LSB +: ACT_W];
      rec_d = wdata[REC_LSB +: REC_W];
    end
    if (wr_imr) imr_d = wdata[IRQ_W-1:0];
    if (wr_isr) isr_d = isr_q & ~wdata[IRQ_W-1:0];
    isr_d = isr_d | isr_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      iordy_q <= 1'b0;
      swap_q  <= 1'b0;
      set_q   <= SET_W'(SET_RST);
      act_q   <= ACT_W'(ACT_RST);
      rec_q   <= REC_W'(REC_RST);
      isr_q   <= '0;
      imr_q   <= '0;
    end else begin
      en_q    <= en_d;
      iordy_q <= iordy_d;
      swap_q  <= swap_d;
      set_q   <= set_d;
      act_q   <= act_d;
      rec_q   <= rec_d;
      isr_q   <= isr_d;
      imr_q   <= imr_d;
    end
  end

  assign en       = en_q;
  assign iordy_en = iordy_q;
  assign swap     = swap_q;
  assign tim_set  = set_q;
  assign tim_act  = act_q;
  assign tim_rec  = rec_q;
  assign isr      = isr_q;
  assign imr      = imr_q;
  assign irq      = |(isr_q & imr_q);

endmodule

// File: rtl/pata_acc_slot.sv
module pata_acc_slot
  import pata_pio_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     acc_valid,
  input  dev_acc_t acc_in,
  input  logic     busy,
  input  logic     pop,
  output logic     full,
  output dev_acc_t acc_out
);

  logic     full_q, full_d;
  dev_acc_t slot_q, slot_d;
  logic     park;

  assign park = acc_valid && (busy || full_q) && (!full_q || pop);

  always_comb begin
    full_d = full_q;
    slot_d = slot_q;
    if (pop) full_d = 1'b0;
    if (park) begin
      full_d = 1'b1;
      slot_d = acc_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      slot_q <= '0;
    end else begin
      full_q <= full_d;
      if (park) slot_q <= slot_d;
    end
  end

  assign full    = full_q;
  assign acc_out = slot_q;

endmodule

// File: rtl/pata_cycle_fsm.sv
module pata_cycle_fsm
  import pata_pio_pkg::*;
#(
  parameter int SET_W = 4,
  parameter int ACT_W = 8,
  parameter int REC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] tim_set,
  input  logic [ACT_W-1:0] tim_act,
  input  logic [REC_W-1:0] tim_rec,
  input  logic             iordy_en,
  input  logic             swap,
  input  logic             iordy,
  input  logic [DW-1:0]    dd_in,
  input  logic             slot_full,
  input  dev_acc_t         slot_acc,
  input  logic             new_valid,
  input  dev_acc_t         new_acc,
  output logic             busy,
  output logic             pop,
  output logic             start_new,
  output logic             done,
  output logic             cs0_n,
  output logic             cs1_n,
  output logic [2:0]       da,
  output logic             dior_n,
  output logic             diow_n,
  output logic [DW-1:0]    dd_out,
  output logic             dd_oe,
  output logic [DW-1:0]    rd_data
);

  localparam int CNT_W0 = (ACT_W > REC_W) ? ACT_W : REC_W;
  localparam int CNT_W  = (CNT_W0 > SET_W) ? CNT_W0 : SET_W;

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  dev_acc_t         cur_q, cur_d;
  logic [DW-1:0]    rd_q, rd_d;
  logic             stall;
  logic             cnt_zero;
  logic             capture;

  assign cnt_zero = (cnt_q == '0);
  assign stall    = iordy_en && !iordy;
  assign capture  = (ph_q == PH_ACTIVE) && cnt_zero && !stall && !cur_q.we;

  always_comb begin
    ph_d      = ph_q;
    cnt_d     = cnt_q;
    cur_d     = cur_q;
    pop       = 1'b0;
    start_new = 1'b0;
    done      = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (slot_full) begin
          pop   = 1'b1;
          cur_d = slot_acc;
          ph_d  = PH_SETUP;
          cnt_d = CNT_W'(tim_set);
        end else if (new_valid) begin
          start_new = 1'b1;
          cur_d     = new_acc;
          ph_d      = PH_SETUP;
          cnt_d     = CNT_W'(tim_set);
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          ph_d  = PH_ACTIVE;
          cnt_d = CNT_W'(tim_act);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else if (!stall) begin
          ph_d  = PH_RECOV;
          cnt_d = CNT_W'(tim_rec);
        end
      end
      PH_RECOV: begin
        if (cnt_zero) begin
          done = 1'b1;
          if (slot_full) begin
            pop   = 1'b1;
            cur_d = slot_acc;
            ph_d  = PH_SETUP;
            cnt_d = CNT_W'(tim_set);
          end else begin
            ph_d = PH_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    rd_d = rd_q;
    if (capture) begin
      if (cur_q.is_word) rd_d = swap ? swap_bytes(dd_in) : dd_in;
      else               rd_d = {8'h00, dd_in[7:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      cur_q <= '0;
      rd_q  <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      cur_q <= cur_d;
      if (capture) rd_q <= rd_d;
    end
  end

  assign busy    = (ph_q != PH_IDLE);
  assign cs0_n   = !(busy && !cur_q.cs1);
  assign cs1_n   = !(busy && cur_q.cs1);
  assign da      = cur_q.da;
  assign dior_n  = !((ph_q == PH_ACTIVE) && !cur_q.we);
  assign diow_n  = !((ph_q == PH_ACTIVE) && cur_q.we);
  assign dd_oe   = busy && cur_q.we;
  assign dd_out  = cur_q.data;
  assign rd_data = rd_q;

endmodule

// File: rtl/pata_pio_host.sv
module pata_pio_host
  import pata_pio_pkg::*;
#(
  parameter int AW      = 8,
  parameter int SET_W   = 4,
  parameter int ACT_W   = 8,
  parameter int REC_W   = 8,
  parameter int IRQ_W   = 2,
  parameter int SET_RST = 6,
  parameter int ACT_RST = 28,
  parameter int REC_RST = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [DW-1:0] ata_dd_in,
  output logic [DW-1:0] ata_dd_out,
  output logic          ata_dd_oe,
  output logic [2:0]    ata_da,
  output logic          ata_cs0_n,
  output logic          ata_cs1_n,
  output logic          ata_dior_n,
  output logic          ata_diow_n,
  input  logic          ata_iordy,
  input  logic          ata_intrq,
  output logic          irq
);

  localparam int ACT_LSB = SET_W;
  localparam int REC_LSB = SET_W + ACT_W;

  logic             wr;
  logic             en, iordy_en, swap;
  logic [SET_W-1:0] tim_set;
  logic [ACT_W-1:0] tim_act;
  logic [REC_W-1:0] tim_rec;
  logic [IRQ_W-1:0] isr, imr;
  logic             busy, pop, start_new, done;
  logic             slot_full;
  dev_acc_t         slot_acc;
  dev_acc_t         acc_in;
  logic             in_window;
  logic             acc_valid;
  logic [AW-1:0]    rel;
  logic [DW-1:0]    rd_data;
  logic [31:0]      rd_mux;
  logic [31:0]      rdata_q;

  assign wr  = bus_sel && bus_we;
  assign rel = bus_addr - AW'(OFS_DATA);

  assign in_window = (bus_addr >= AW'(OFS_DATA)) && (bus_addr <= AW'(OFS_ALT))
                     && (bus_addr[1:0] == 2'b00);
  assign acc_valid = bus_sel && en && in_window;

  always_comb begin
    acc_in         = '0;
    acc_in.we      = bus_we;
    acc_in.cs1     = (bus_addr == AW'(OFS_ALT));
    acc_in.da      = acc_in.cs1 ? 3'd6 : rel[4:2];
    acc_in.is_word = (bus_addr == AW'(OFS_DATA));
    if (bus_we) begin
      if (acc_in.is_word) acc_in.data = swap ? swap_bytes(bus_wdata[DW-1:0]) : bus_wdata[DW-1:0];
      else                acc_in.data = {8'h00, bus_wdata[7:0]};
    end
  end

  pata_regfile #(
    .SET_W(SET_W), .ACT_W(ACT_W), .REC_W(REC_W), .IRQ_W(IRQ_W),
    .SET_RST(SET_RST), .ACT_RST(ACT_RST), .REC_RST(REC_RST)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr && (bus_addr == AW'(OFS_CTRL))),
    .wr_cfg   (wr && (bus_addr == AW'(OFS_CFG))),
    .wr_tim   (wr && (bus_addr == AW'(OFS_TIM))),
    .wr_isr   (wr && (bus_addr == AW'(OFS_ISR))),
    .wr_imr   (wr && (bus_addr == AW'(OFS_IMR))),
    .wdata    (bus_wdata),
    .cyc_done (done),
    .dev_intrq(ata_intrq),
    .en       (en),
    .iordy_en (iordy_en),
    .swap     (swap),
    .tim_set  (tim_set),
    .tim_act  (tim_act),
    .tim_rec  (tim_rec),
    .isr      (isr),
    .imr      (imr),
    .irq      (irq)
  );

  pata_acc_slot u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_in   (acc_in),
    .busy     (busy),
    .pop      (pop),
    .full     (slot_full),
    .acc_out  (slot_acc)
  );

  pata_cycle_fsm #(.SET_W(SET_W), .ACT_W(ACT_W), .REC_W(REC_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .tim_set  (tim_set),
    .tim_act  (tim_act),
    .tim_rec  (tim_rec),
    .iordy_en (iordy_en),
    .swap     (swap),
    .iordy    (ata_iordy),
    .dd_in    (ata_dd_in),
    .slot_full(slot_full),
    .slot_acc (slot_acc),
    .new_valid(acc_valid && !busy && !slot_full),
    .new_acc  (acc_in),
    .busy     (busy),
    .pop      (pop),
    .start_new(start_new),
    .done     (done),
    .cs0_n    (ata_cs0_n),
    .cs1_n    (ata_cs1_n),
    .da       (ata_da),
    .dior_n   (ata_dior_n),
    .diow_n   (ata_diow_n),
    .dd_out   (ata_dd_out),
    .dd_oe    (ata_dd_oe),
    .rd_data  (rd_data)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(OFS_CTRL)) rd_mux[0] = en;
    if (bus_addr == AW'(OFS_ISR))  rd_mux[IRQ_W-1:0] = isr;
    if (bus_addr == AW'(OFS_IMR))  rd_mux[IRQ_W-1:0] = imr;
    if (bus_addr == AW'(OFS_CFG)) begin
      rd_mux[CFG_IORDY_BIT] = iordy_en;
      rd_mux[CFG_SWAP_BIT]  = swap;
    end
    if (bus_addr == AW'(OFS_TIM)) begin
      rd_mux[0 +: SET_W]       = tim_set;
      rd_mux[ACT_LSB +: ACT_W] = tim_act;
      rd_mux[REC_LSB +: REC_W] = tim_rec;
    end
    if (bus_addr == AW'(OFS_RDAT)) rd_mux[DW-1:0] = rd_data;
    if (bus_addr == AW'(OFS_STAT)) rd_mux[31:28] = {2'b00, slot_full, busy};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_sel && !bus_we) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/pata_pio_host_chk.sv
module pata_pio_host_chk (
  input logic clk,
  input logic rst_n,
  input logic cs0_n,
  input logic cs1_n,
  input logic dior_n,
  input logic diow_n,
  input logic dd_oe,
  input logic iordy,
  input logic iordy_en,
  input logic ctrl_en,
  input logic slot_full,
  input logic done,
  input logic isr0
);

  logic strobe_low;
  logic cs_low;
  assign strobe_low = !dior_n || !diow_n;
  assign cs_low     = !cs0_n || !cs1_n;

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));

  a_r3_strobe_under_cs: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> cs_low);

  a_r5_one_chip_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!cs0_n, !cs1_n}));

  a_r12_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> dior_n);

  a_r4_ready_holds_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_low && iordy_en && !iordy) |=> strobe_low);

  a_r2_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low && $past(!cs0_n == 1'b0 && !cs1_n == 1'b0)) |-> ($past(ctrl_en) || $past(slot_full)));

  a_r10_done_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> isr0);

endmodule

bind pata_pio_host pata_pio_host_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs0_n    (ata_cs0_n),
  .cs1_n    (ata_cs1_n),
  .dior_n   (ata_dior_n),
  .diow_n   (ata_diow_n),
  .dd_oe    (ata_dd_oe),
  .iordy    (ata_iordy),
  .iordy_en (iordy_en),
  .ctrl_en  (en),
  .slot_full(slot_full),
  .done     (done),
  .isr0     (isr[0])
);

// File: tb/sim_pata_pio_host.sv
`timescale 1ns/1ps
module sim_pata_pio_host;

  logic        clk;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] ata_dd_in, ata_dd_out;
  logic        ata_dd_oe;
  logic [2:0]  ata_da;
  logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n;
  logic        ata_iordy, ata_intrq, irq;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  pata_pio_host u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ata_dd_in(ata_dd_in), .ata_dd_out(ata_dd_out), .ata_dd_oe(ata_dd_oe),
    .ata_da(ata_da), .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n),
    .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
    .ata_iordy(ata_iordy), .ata_intrq(ata_intrq), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  typedef struct { bit we; bit cs1; int da; int dat; } macc_t;
  macc_t q[$];
  macc_t cur;
  int m_ph, m_cnt;
  bit m_en, m_iordy_en, m_swap;
  int m_set, m_act, m_rec;

  function automatic int sw16(int v);
    return ((v & 8'hFF) << 8) | ((v >> 8) & 8'hFF);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; q.delete();
      cur = '{0, 0, 0, 0};
      m_en = 0; m_iordy_en = 0; m_swap = 0;
      m_set = 6; m_act = 28; m_rec = 23;
    end else begin
      bit busy0, full0, acc, popped;
      macc_t inc;
      busy0  = (m_ph != 0);
      full0  = (q.size() != 0);
      popped = 0;
      acc = bus_sel && m_en && bus_addr >= 8'h54 && bus_addr <= 8'h74 && bus_addr[1:0] == 2'b00;
      inc.we  = bus_we;
      inc.cs1 = (bus_addr == 8'h74);
      inc.da  = inc.cs1 ? 6 : (int'(bus_addr) - 'h54) / 4;
      inc.dat = 0;
      if (bus_we) inc.dat = (bus_addr == 8'h54) ? (m_swap ? sw16(bus_wdata[15:0]) : int'(bus_wdata[15:0]))
                                                 : int'(bus_wdata[7:0]);
      case (m_ph)
        0: if (full0) begin cur = q.pop_front(); popped = 1; m_ph = 1; m_cnt = m_set; end
           else if (acc) begin cur = inc; m_ph = 1; m_cnt = m_set; end
        1: if (m_cnt == 0) begin m_ph = 2; m_cnt = m_act; end else m_cnt--;
        2: if (m_cnt != 0) m_cnt--;
           else if (!(m_iordy_en && !ata_iordy)) begin m_ph = 3; m_cnt = m_rec; end
        default: if (m_cnt == 0) begin
             if (full0) begin cur = q.pop_front(); popped = 1; m_ph = 1; m_cnt = m_set; end
             else m_ph = 0;
           end else m_cnt--;
      endcase
      if (acc && (busy0 || full0) && (!full0 || popped)) q.push_back(inc);
      if (bus_sel && bus_we) begin
        if (bus_addr == 8'h00) m_en = bus_wdata[0];
        if (bus_addr == 8'h18) begin m_iordy_en = bus_wdata[1]; m_swap = bus_wdata[6]; end
        if (bus_addr == 8'h2C) begin
          m_set = bus_wdata[3:0]; m_act = bus_wdata[11:4]; m_rec = bus_wdata[19:12];
        end
      end
    end
  end

  // per-clock comparison of the device-side pins (R3, R5, R9, R12)
  int wr_strobes = 0;
  bit prev_diow = 1;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit ecs0, ecs1, erd, ewr, eoe, ok;
      ecs0 = !(m_ph != 0 && !cur.cs1);
      ecs1 = !(m_ph != 0 && cur.cs1);
      erd  = !(m_ph == 2 && !cur.we);
      ewr  = !(m_ph == 2 && cur.we);
      eoe  = (m_ph != 0 && cur.we);
      ok = (ata_cs0_n == ecs0) && (ata_cs1_n == ecs1) && (ata_dior_n == erd) &&
           (ata_diow_n == ewr) && (ata_dd_oe == eoe);
      if (m_ph != 0 && int'(ata_da) != cur.da) ok = 0;
      if (eoe && int'(ata_dd_out) != cur.dat) ok = 0;
      total++;
      if (!ok) begin
        bad++;
        $display("FAIL R3/R5/R12 pins t=%0t got cs0=%b cs1=%b rd=%b wr=%b oe=%b da=%0d dd=%h exp cs0=%b cs1=%b rd=%b wr=%b oe=%b da=%0d dd=%h",
                 $time, ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_dd_oe, ata_da, ata_dd_out,
                 ecs0, ecs1, erd, ewr, eoe, cur.da, cur.dat[15:0]);
      end
      if (prev_diow && !ata_diow_n) wr_strobes++;
      prev_diow = ata_diow_n;
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd32(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int i = 0; i < 400; i++) begin
      rd32(8'h80, d);
      if (d[31:28] == 4'h0) return;
    end
    check("R8 idle timeout", 1, 0);
  endtask

  task automatic wait_last_recovery();
    for (int i = 0; i < 400 && !(m_ph == 3 && m_cnt == 0); i++) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] d;
    int lowc;
    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    ata_dd_in = 16'h1234; ata_iordy = 1; ata_intrq = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 pins idle", {ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n}, 4'hF);
    rd32(8'h00, d); check("R1 control", d, 32'h0);
    rd32(8'h2C, d); check("R1 timing", d, 32'h000171C6);
    rd32(8'h18, d); check("R1 config", d, 32'h0);

    // R2 disabled: no cycle
    wr32(8'h70, 32'hEC);
    repeat (4) @(negedge clk);
    check("R2 no strobe while disabled", wr_strobes, 0);
    rd32(8'h80, d); check("R2/R8 status idle", d, 32'h0);

    // enable, fast timing: setup 1, active 3, recovery 2
    wr32(8'h2C, 32'h00002031);
    wr32(8'h00, 32'h1);

    // R3/R5/R12 task-file write, R8 busy
    wr32(8'h60, 32'hFFFF_FFA5);
    rd32(8'h80, d); check("R8 busy nibble", d, 32'h1000_0000);
    wait_idle();
    check("R3 one write strobe", wr_strobes, 1);

    // R5 control block
    wr32(8'h74, 32'h0E);
    @(negedge clk);
    check("R5 cs1 for 0x74", {ata_cs0_n, ata_cs1_n, ata_da}, {2'b10, 3'd6});
    wait_idle();

    // R6 posted reads
    ata_dd_in = 16'h1234;
    rd32(8'h54, d); wait_idle();
    rd32(8'h7C, d); check("R6 word read", d, 32'h1234);
    rd32(8'h5C, d); wait_idle();
    rd32(8'h7C, d); check("R6 byte read", d, 32'h34);

    // R7 swap
    wr32(8'h18, 32'h40);
    rd32(8'h54, d); wait_idle();
    rd32(8'h7C, d); check("R7 swapped read", d, 32'h3412);
    rd32(8'h64, d); wait_idle();
    rd32(8'h7C, d); check("R7 byte unswapped", d, 32'h34);
    wr32(8'h54, 32'h0000_ABCD);
    while (ata_diow_n) @(negedge clk);
    check("R7 swapped write", ata_dd_out, 16'hCDAB);
    wait_idle();
    wr32(8'h18, 32'h0);

    // R9 holding slot and drop
    wr_strobes = 0;
    wr32(8'h60, 32'h11);
    wr32(8'h64, 32'h22);
    rd32(8'h80, d); check("R8/R9 slot occupied", d, 32'h3000_0000);
    wr32(8'h68, 32'h33);
    wait_idle();
    check("R9 two cycles, third dropped", wr_strobes, 2);

    // R9 coincidence: access on last recovery clock
    wr_strobes = 0;
    wr32(8'h60, 32'h44);
    wait_last_recovery();
    wr32(8'h64, 32'h55);
    wait_idle();
    check("R9 access on last recovery kept", wr_strobes, 2);

    // R4 ready extension
    wr32(8'h2C, 32'h00000010);
    wr32(8'h18, 32'h2);
    ata_iordy = 0;
    wr32(8'h60, 32'h66);
    while (ata_diow_n) @(negedge clk);
    lowc = 0;
    while (!ata_diow_n && lowc < 100) begin
      lowc++;
      if (lowc == 5) ata_iordy = 1;
      @(negedge clk);
    end
    check("R4 stretched strobe", lowc, 5);
    wait_idle();
    wr32(8'h18, 32'h0);
    ata_iordy = 0;
    wr32(8'h60, 32'h77);
    while (ata_diow_n) @(negedge clk);
    lowc = 0;
    while (!ata_diow_n && lowc < 100) begin lowc++; @(negedge clk); end
    check("R4 ready ignored when off", lowc, 2);
    ata_iordy = 1;
    wait_idle();

    // R10/R11 interrupts
    wr32(8'h10, 32'h3);
    rd32(8'h10, d); check("R10 cleared", d, 32'h0);
    wr32(8'h14, 32'h1);
    wr32(8'h60, 32'h88);
    wait_idle();
    check("R11 irq on done", irq, 1);
    wr32(8'h10, 32'h1);
    check("R10/R11 w1c drops irq", irq, 0);
    wr32(8'h2C, 32'h00002031);
    wr32(8'h60, 32'h99);
    wait_last_recovery();
    wr32(8'h10, 32'h1);
    rd32(8'h10, d); check("R10 set wins over clear", d, 32'h1);
    wait_idle();
    wr32(8'h10, 32'h1);
    ata_intrq = 1; @(negedge clk); ata_intrq = 0; @(negedge clk);
    rd32(8'h10, d); check("R10 device intrq", d, 32'h2);
    check("R11 masked intrq", irq, 0);
    wr32(8'h14, 32'h2);
    check("R11 unmasked intrq", irq, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule